// File: doc/BRIEF.md
# Flash Operation Status and Interrupt Unit

This unit sits beside a flash memory controller and turns the activity of its operation engine and its request checkers into software-visible status and one interrupt line. It watches the engine's busy level and records a completion flag each time that level drops, whether the operation finished cleanly or not. It also records four error kinds as separate sticky flags: misaligned access, wrong access width, bad request order, and write to a protected area. Each error input is a small vector with one lane per request checker (program, erase, read), so an error from any request kind is captured.

Software sees a control word with two enables, one for completion and one for errors, and a status word whose flags are cleared by writing 1. When errors are enabled, any new error also sets a summary operation-error flag. While a streamed run of write requests is producing errors, clear writes to the error flags are refused. This stops software from losing an error that belongs to a run still in progress. The interrupt line is a registered level built from the flags and their enables.

Top module: `fsi_status_irq`

## Requirements
- R1: After reset the control word, the status word and `irq_o` all read 0.
- R2: Status bit 0 (completion) sets on the clock edge at which `busy_i` is sampled 0 after being sampled 1 at the previous edge. This holds whatever the error inputs are doing at that time. A rising `busy_i` sets nothing.
- R3: Status bits 2 (protection), 3 (alignment), 4 (width) and 5 (sequence) each set on the edge at which any lane of `err_wprot_i`, `err_align_i`, `err_width_i` or `err_seq_i`, respectively, is sampled 1. Each bit stays set until it is cleared.
- R4: Status bit 1 (operation error) sets together with an error flag only when control bit 1 (error enable) is 1 at that edge. With the enable at 0 it stays clear.
- R5: `irq_o` is a register. One edge after the flags and enables change, it equals (bit 0 AND control bit 0) OR (any of status bits 2..5 AND control bit 1).
- R6: Writing the status word (address 1) clears each flag whose data bit is 1. Data bits at 0 leave their flags unchanged. If a set event and a clear hit the same flag at the same edge, the flag ends up set.
- R7: An error event sampled while `burst_i` is 1 locks the unit. From the next edge onwards, clear writes to status bits 1..5 are ignored while `burst_i` stays 1. Bit 0 remains clearable. A burst with no error does not lock.
- R8: The lock is still in force at the edge where `burst_i` is first sampled 0. Clear writes take effect again from the following edge.
- R9: The control word (address 0) holds the completion enable in bit 0 and the error enable in bit 1, and reads back as written. Addresses 2 and 3 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Operation engine busy level |
| err_align_i | input | N_CHK | Alignment error pulse, one lane per request checker |
| err_width_i | input | N_CHK | Access-width error pulse, one lane per checker |
| err_seq_i | input | N_CHK | Sequence error pulse, one lane per checker |
| err_wprot_i | input | N_CHK | Protection violation pulse, one lane per checker |
| burst_i | input | 1 | High during a run of back-to-back write requests |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| irq_o | output | 1 | Registered interrupt level |

## Verification
The bench builds the unit with its defaults: three checker lanes, a 2-bit address and an 8-bit data word. Three lanes let each error kind be driven from the program, erase and read checkers in turn. The two spare addresses exercise the read-as-zero and ignored-write decode, and the two bits above the flags show that writes there are harmless. Directed scenarios cover the edges where lock and clear meet: a clear written in the same cycle that the burst falls, a set that collides with a clear, and an error that arrives together with the busy fall.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  localparam int NFLAG   = 6;
  localparam int F_EOP   = 0;
  localparam int F_OPERR = 1;
  localparam int F_WPROT = 2;
  localparam int F_ALIGN = 3;
  localparam int F_WIDTH = 4;
  localparam int F_SEQ   = 5;

  localparam int C_EOPIE = 0;
  localparam int C_ERRIE = 1;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;

  // flags whose clears are held off during an erroring burst
  localparam logic [NFLAG-1:0] LOCK_MASK = 6'b111110;
  // flags that feed the error interrupt term
  localparam logic [NFLAG-1:0] ERR_MASK  = 6'b111100;
endpackage

// File: rtl/fsi_fall_det.sv
module fsi_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/fsi_w1c_flag.sv
module fsi_w1c_flag #(
  parameter bit LOCKABLE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic lock_i,
  output logic q_o
);
  logic blocked;
  assign blocked = lock_i & LOCKABLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_o <= 1'b0;
    else if (set_i)             q_o <= 1'b1;
    else if (clr_i && !blocked) q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !blocked && !set_i) |=> !q_o); // R6
endmodule

// File: rtl/fsi_clr_lock.sv
module fsi_clr_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic burst_i,
  input  logic err_evt_i,
  output logic lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lock_o <= 1'b0;
    else if (!burst_i)  lock_o <= 1'b0;
    else if (err_evt_i) lock_o <= 1'b1;
  end

  AST_LOCK_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_i && err_evt_i) |=> lock_o); // R7
  AST_LOCK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_i |=> !lock_o); // R8
endmodule

// File: rtl/fsi_irq_gen.sv
module fsi_irq_gen
  import fsi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] stat_i,
  input  logic             eop_ie_i,
  input  logic             err_ie_i,
  output logic             irq_o
);
  logic err_any;
  assign err_any = |(stat_i & ERR_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= (stat_i[F_EOP] & eop_ie_i) | (err_any & err_ie_i);
  end

  AST_IRQ_EOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i[F_EOP] && eop_ie_i) |=> irq_o); // R5
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_i[F_EOP] && !err_any) |=> !irq_o); // R5
endmodule

// File: rtl/fsi_status_irq.sv
module fsi_status_irq
  import fsi_pkg::*;
#(
  parameter int N_CHK  = 3,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic [N_CHK-1:0]  err_align_i,
  input  logic [N_CHK-1:0]  err_width_i,
  input  logic [N_CHK-1:0]  err_seq_i,
  input  logic [N_CHK-1:0]  err_wprot_i,
  input  logic              burst_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

  logic             busy_fall;
  logic             err_evt;
  logic             lock_q;
  logic             eop_ie_q, err_ie_q;
  logic             ctrl_we, stat_we;
  logic [NFLAG-1:0] set_vec, clr_vec, stat_q;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:NFLAG];

  fsi_fall_det u_busy_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (busy_i),
    .fall_o (busy_fall)
  );

  assign set_vec[F_EOP]   = busy_fall;
  assign set_vec[F_WPROT] = |err_wprot_i;
  assign set_vec[F_ALIGN] = |err_align_i;
  assign set_vec[F_WIDTH] = |err_width_i;
  assign set_vec[F_SEQ]   = |err_seq_i;
  assign err_evt          = |(set_vec & ERR_MASK);
  assign set_vec[F_OPERR] = err_evt & err_ie_q;

  assign ctrl_we = reg_we_i && (reg_addr_i == A_CTRL);
  assign stat_we = reg_we_i && (reg_addr_i == A_STAT);
  assign clr_vec = {NFLAG{stat_we}} & reg_wdata_i[NFLAG-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eop_ie_q <= 1'b0;
      err_ie_q <= 1'b0;
    end else if (ctrl_we) begin
      eop_ie_q <= reg_wdata_i[C_EOPIE];
      err_ie_q <= reg_wdata_i[C_ERRIE];
    end
  end

  fsi_clr_lock u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .burst_i   (burst_i),
    .err_evt_i (err_evt),
    .lock_o    (lock_q)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    fsi_w1c_flag #(.LOCKABLE(LOCK_MASK[g])) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .lock_i (lock_q),
      .q_o    (stat_q[g])
    );
  end

  fsi_irq_gen u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stat_i   (stat_q),
    .eop_ie_i (eop_ie_q),
    .err_ie_i (err_ie_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_CTRL) begin
      reg_rdata_o[C_EOPIE] = eop_ie_q;
      reg_rdata_o[C_ERRIE] = err_ie_q;
    end else if (reg_addr_i == A_STAT) begin
      reg_rdata_o[NFLAG-1:0] = stat_q;
    end
  end

  AST_EOP_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_fall |=> stat_q[F_EOP]); // R2
  AST_OPERR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_evt && err_ie_q) |=> stat_q[F_OPERR]); // R4
  AST_LOCK_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> (($past(stat_q) & ~stat_q & LOCK_MASK) == '0)); // R7
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we |=> ($stable(eop_ie_q) && $stable(err_ie_q))); // R9
endmodule

// File: tb/sim_fsi_status_irq.sv
module sim_fsi_status_irq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       busy_i = 1'b0;
  logic [2:0] err_align_i = '0, err_width_i = '0, err_seq_i = '0, err_wprot_i = '0;
  logic       burst_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  fsi_status_irq #(.N_CHK(3), .ADDR_W(2), .DATA_W(8)) u0 (.*);

  task automatic tick();
    @(posedge clk_i);
    #5;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic chk_stat(input string req, input logic [7:0] exp);
    logic [7:0] d;
    rd(2'd1, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
    chk_stat("R1 stat", 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr(2'd0, 8'h03); rd(2'd0, d); chk("R9 ctrl=3", d, 8'h03);
    wr(2'd0, 8'h02); rd(2'd0, d); chk("R9 ctrl=2", d, 8'h02);
    wr(2'd3, 8'hFF); rd(2'd0, d); chk("R9 unmapped write", d, 8'h02);
    chk_stat("R9 unmapped write stat", 8'h00);
    rd(2'd2, d); chk("R9 addr2 reads 0", d, 8'h00);
    rd(2'd3, d); chk("R9 addr3 reads 0", d, 8'h00);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_eop();
    busy_i = 1'b1; tick();
    chk_stat("R2 rise sets nothing", 8'h00);
    tick();
    busy_i = 1'b0; tick();
    chk_stat("R2 fall sets eop", 8'h01);
    chk("R5 irq off when disabled", {7'd0, irq_o}, 8'h00);
    wr(2'd0, 8'h01);
    chk("R5 irq one edge late", {7'd0, irq_o}, 8'h00);
    tick();
    chk("R5 irq eop", {7'd0, irq_o}, 8'h01);
    wr(2'd1, 8'h00); chk_stat("R6 write 0 no effect", 8'h01);
    wr(2'd1, 8'h01); chk_stat("R6 write 1 clears", 8'h00);
    tick();
    chk("R5 irq drops", {7'd0, irq_o}, 8'h00);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_eop_err();
    busy_i = 1'b1; tick();
    busy_i = 1'b0; err_align_i = 3'b001; tick();
    err_align_i = '0;
    chk_stat("R2 eop with error, R4 no operr", 8'h09);
    wr(2'd1, 8'hFF); chk_stat("R6 clear all", 8'h00);
  endtask

  task automatic t_err_src();
    err_width_i = 3'b010; tick(); err_width_i = '0;
    chk_stat("R3 width lane1, R4 no operr", 8'h10);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h02);
    err_wprot_i = 3'b100; tick(); err_wprot_i = '0;
    chk_stat("R3 wprot, R4 operr", 8'h06);
    tick();
    chk("R5 irq err", {7'd0, irq_o}, 8'h01);
    err_seq_i = 3'b100; tick(); err_seq_i = '0;
    chk_stat("R3 seq lane2", 8'h26);
    err_align_i = 3'b001; tick(); err_align_i = '0;
    chk_stat("R3 align lane0", 8'h2E);
    wr(2'd1, 8'hFF); chk_stat("R6 clear all", 8'h00);
    err_seq_i = 3'b001;
    wr(2'd1, 8'h20);
    err_seq_i = '0;
    chk_stat("R6 set wins", 8'h22);
    wr(2'd1, 8'hFF); chk_stat("R6 cleared", 8'h00);
    tick();
    chk("R5 irq idle", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_lock();
    busy_i = 1'b1; tick();
    busy_i = 1'b0; tick();
    burst_i = 1'b1; err_align_i = 3'b001; tick(); err_align_i = '0;
    chk_stat("R7 burst error", 8'h0B);
    tick();
    wr(2'd1, 8'hFF); chk_stat("R7 errors locked, eop cleared", 8'h0A);
    err_width_i = 3'b010; tick(); err_width_i = '0;
    chk_stat("R7 new error in burst", 8'h1A);
    wr(2'd1, 8'hFF); chk_stat("R7 still locked", 8'h1A);
    burst_i = 1'b0;
    wr(2'd1, 8'hFF); chk_stat("R8 locked at falling edge", 8'h1A);
    wr(2'd1, 8'hFF); chk_stat("R8 released", 8'h00);
    err_seq_i = 3'b010; tick(); err_seq_i = '0;
    burst_i = 1'b1; tick();
    wr(2'd1, 8'hFF); chk_stat("R7 clean burst no lock", 8'h00);
    burst_i = 1'b0; tick();
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #5 rst_ni = 1'b1;
    tick();
    t_reset();
    t_ctrl();
    t_eop();
    t_eop_err();
    t_err_src();
    t_lock();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule